// File: doc/BRIEF.md
# Physical Page Access and Dirty Tracker

This block sits on the system memory bus next to the memory controller. For every physical page frame it keeps two bits: a referenced bit and a changed bit. It observes each completed bus transaction, whether it comes from a processor or from a DMA or I/O master. Any access marks the addressed frame as referenced. A write also marks the frame as changed. The bits are indexed by physical page number, and the processor never stores them anywhere else, so this array is the only copy.

Software reaches the bits through a small register port:

- A selector register picks a frame.
- A bits register reads that frame's pair, or clears either bit with a mask.
- A command register starts a sweep that clears every frame, one frame per clock.

Bus activity that lands in the tracker's own register page is not counted. A bit set by traffic always beats a clear of the same frame in the same cycle, so no reference is lost.

Pages are 4 KiB, so the frame number is taken from address bits [31:12]. The number of tracked frames is a parameter.

Top module: `pageRefTracker`

## Requirements
- R1: After reset every frame's referenced and changed bits are 0, `busy` is 0 and `ioRdata` is 0.
- R2: A snooped read to a tracked frame sets that frame's referenced bit and leaves its changed bit unchanged.
- R3: A snooped write to a tracked frame sets both its referenced bit and its changed bit.
- R4: A snooped access whose page number (`snpAddr[31:12]`) is FRAMES or more changes no frame.
- R5: A snooped access whose page equals the register window page (REG_BASE, default 0x000F_F000) changes no frame.
- R6: Writing register 0 (`ioAddr`=0) loads the frame selector from `ioWdata[7:0]`. A read returns its result on `ioRdata` in the cycle after the request, and `ioRdata` holds that value until the next read. The read results are:
  - register 0 returns the selector;
  - register 1 returns the selected frame as changed bit in bit 1 and referenced bit in bit 0;
  - register 3 returns 0.
- R7: Writing register 1 clears the selected frame's referenced bit if `ioWdata[0]` is 1, and clears its changed bit if `ioWdata[1]` is 1.
- R8: When a snooped access and a register-1 clear hit the same frame in the same cycle, the bits the snoop sets end up 1.
- R9: Writing register 2 with `ioWdata[0]`=1 while idle starts a sweep. The sweep raises `busy` for exactly FRAMES cycles and clears frame k in the k-th busy cycle, counting from 0.
- R10: Snooped accesses during a sweep still set bits. If a set hits the frame being swept in that same cycle, the set wins.
- R11: Reading register 2 returns `busy` in bit 0. A start command issued while `busy` is 1 is ignored and does not lengthen the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | A bus transaction completes this cycle |
| snpWrite | input | 1 | The completing transaction is a write |
| snpAddr | input | 32 | Physical address of the transaction |
| ioValid | input | 1 | Register port request |
| ioWrite | input | 1 | Register port request is a write |
| ioAddr | input | 2 | Register select: 0 selector, 1 bits, 2 command/status, 3 reserved |
| ioWdata | input | 32 | Register write data |
| ioRdata | output | 32 | Register read data, valid the cycle after a read |
| busy | output | 1 | Clear-all sweep in progress |

## Verification
The snoop path competes in the same cycle with two clears:

- a software clear of the selected frame;
- a sweep clear of the frame under the sweep pointer.

The bench provokes the first collision by issuing a register-1 clear and a snooped read, then a snooped write, to the selected frame in the same cycle. It provokes the second by timing snoops to the exact busy cycle in which the sweep reaches the target frame. In every case the outcome is judged by reading the frame back through the register port. A behavioural model that applies clears before sets is compared on every clock. Directed readbacks with fixed expected values confirm that the set survived.

// File: rtl/pageTrackPkg.sv
package pageTrackPkg;

  // Widest page index the strobe bus carries (32-bit address, 4 KiB page).
  localparam int PIDX_W = 20;

  typedef enum logic [1:0] {
    RD_SEL  = 2'd0,
    RD_BITS = 2'd1,
    RD_STAT = 2'd2,
    RD_ZERO = 2'd3
  } rdKindT;

  typedef struct packed {
    logic              setEn;
    logic              setWr;
    logic [PIDX_W-1:0] setIdx;
    logic              clrEn;
    logic [1:0]        clrMask;
    logic [PIDX_W-1:0] selIdx;
    logic              sweepEn;
    logic [PIDX_W-1:0] sweepIdx;
    logic              rdEn;
    rdKindT            rdKind;
    logic              busy;
  } trackStbT;

endpackage

// File: rtl/pageTrackCtrl.sv
module pageTrackCtrl
  import pageTrackPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int FRAMES     = 256,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h000F_F000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [1:0]        ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output trackStbT          stb
);

  localparam int IDX_W = $clog2(FRAMES);
  localparam int PN_W  = ADDR_W - PAGE_SHIFT;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);
  localparam logic [PN_W-1:0]  WIN_PAGE = REG_BASE[ADDR_W-1:PAGE_SHIFT];

  logic [PN_W-1:0]  pageNum;
  logic             inRange;
  logic             inWindow;
  logic             wrSel;
  logic             wrBits;
  logic             startCmd;
  logic             startOk;
  logic [IDX_W-1:0] selQ;
  logic [IDX_W-1:0] sweepQ;
  logic             busyQ;
  logic             unusedBits;

  assign unusedBits = ^{snpAddr[PAGE_SHIFT-1:0], ioWdata[DATA_W-1:IDX_W]};

  // Snoop decode: frame number, range check, own-window exclusion.
  assign pageNum  = snpAddr[ADDR_W-1:PAGE_SHIFT];
  assign inRange  = pageNum < PN_W'(FRAMES);
  assign inWindow = pageNum == WIN_PAGE;

  // Register port decode.
  assign wrSel    = ioValid && ioWrite && (ioAddr == 2'd0);
  assign wrBits   = ioValid && ioWrite && (ioAddr == 2'd1);
  assign startCmd = ioValid && ioWrite && (ioAddr == 2'd2) && ioWdata[0];
  assign startOk  = startCmd && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (wrSel) begin
      selQ <= ioWdata[IDX_W-1:0];
    end
  end

  // Sweep engine: one frame per cycle while busy.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      sweepQ <= '0;
    end else if (startOk) begin
      busyQ  <= 1'b1;
      sweepQ <= '0;
    end else if (busyQ) begin
      if (sweepQ == LAST_IDX) busyQ <= 1'b0;
      sweepQ <= sweepQ + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.setEn    = snpValid && inRange && !inWindow;
    stb.setWr    = snpWrite;
    stb.setIdx   = PIDX_W'(pageNum);
    stb.clrEn    = wrBits;
    stb.clrMask  = ioWdata[1:0];
    stb.selIdx   = PIDX_W'(selQ);
    stb.sweepEn  = busyQ;
    stb.sweepIdx = PIDX_W'(sweepQ);
    stb.rdEn     = ioValid && !ioWrite;
    stb.rdKind   = rdKindT'(ioAddr);
    stb.busy     = busyQ;
  end

  assert_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |-> (snpAddr[ADDR_W-1:PAGE_SHIFT] < PN_W'(FRAMES)));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpAddr[ADDR_W-1:PAGE_SHIFT] == WIN_PAGE) |-> !stb.setEn);

  assert_sweep_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && sweepQ == LAST_IDX && !startCmd) |=> !busyQ);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startCmd && sweepQ != LAST_IDX) |=> (busyQ && sweepQ == $past(sweepQ) + 1'b1));

endmodule

// File: rtl/pageTrackData.sv
module pageTrackData
  import pageTrackPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAMES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  trackStbT          stb,
  output logic [DATA_W-1:0] ioRdata
);

  localparam int IDX_W = $clog2(FRAMES);

  logic [FRAMES-1:0] rBits;
  logic [FRAMES-1:0] cBits;
  logic [IDX_W-1:0]  rdIdx;

  assign rdIdx = stb.selIdx[IDX_W-1:0];

  // One storage cell pair per frame; a set overrides any clear.
  for (genvar i = 0; i < FRAMES; i++) begin : gFrame
    logic rQ, cQ;
    logic hitSet, hitClr, hitSweep;
    assign hitSet   = stb.setEn   && (stb.setIdx   == PIDX_W'(i));
    assign hitClr   = stb.clrEn   && (stb.selIdx   == PIDX_W'(i));
    assign hitSweep = stb.sweepEn && (stb.sweepIdx == PIDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rQ <= 1'b0;
        cQ <= 1'b0;
      end else begin
        if (hitSet)                                   rQ <= 1'b1;
        else if ((hitClr && stb.clrMask[0]) || hitSweep) rQ <= 1'b0;
        if (hitSet && stb.setWr)                      cQ <= 1'b1;
        else if ((hitClr && stb.clrMask[1]) || hitSweep) cQ <= 1'b0;
      end
    end

    assign rBits[i] = rQ;
    assign cBits[i] = cQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdata <= '0;
    end else if (stb.rdEn) begin
      unique case (stb.rdKind)
        RD_SEL:  ioRdata <= {{(DATA_W-IDX_W){1'b0}}, rdIdx};
        RD_BITS: ioRdata <= {{(DATA_W-2){1'b0}}, cBits[rdIdx], rBits[rdIdx]};
        RD_STAT: ioRdata <= {{(DATA_W-1){1'b0}}, stb.busy};
        default: ioRdata <= '0;
      endcase
    end
  end

  assert_read_sets_r_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |=> rBits[$past(stb.setIdx[IDX_W-1:0])]);

  assert_write_sets_c_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setEn && stb.setWr) |=> cBits[$past(stb.setIdx[IDX_W-1:0])]);

  assert_clear_r_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrEn && stb.clrMask[0] && !(stb.setEn && stb.setIdx == stb.selIdx))
      |=> !rBits[$past(rdIdx)]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setEn && stb.clrEn && stb.setIdx == stb.selIdx)
      |=> rBits[$past(rdIdx)]);

  assert_sweep_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sweepEn && !(stb.setEn && stb.setIdx == stb.sweepIdx))
      |=> (!rBits[$past(stb.sweepIdx[IDX_W-1:0])] && !cBits[$past(stb.sweepIdx[IDX_W-1:0])]));

  assert_sweep_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sweepEn && stb.setEn && stb.setIdx == stb.sweepIdx)
      |=> rBits[$past(stb.sweepIdx[IDX_W-1:0])]);

endmodule

// File: rtl/pageRefTracker.sv
module pageRefTracker
  import pageTrackPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int FRAMES     = 256,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h000F_F000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [1:0]        ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              busy
);

  trackStbT stb;

  pageTrackCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .FRAMES(FRAMES), .REG_BASE(REG_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .stb(stb)
  );

  pageTrackData #(
    .DATA_W(DATA_W), .FRAMES(FRAMES)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .ioRdata(ioRdata)
  );

  assign busy = stb.busy;

endmodule

// File: tb/sim_pageRefTracker.sv
module sim_pageRefTracker;

  localparam int FR       = 256;
  localparam int WIN_PAGE = 32'h000F_F000 >> 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        snpValid = 1'b0, snpWrite = 1'b0;
  logic [31:0] snpAddr = '0;
  logic        ioValid = 1'b0, ioWrite = 1'b0;
  logic [1:0]  ioAddr = '0;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        busy;

  always #2.5 clk = ~clk;

  pageRefTracker u0 (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .snpWrite(snpWrite),
    .snpAddr(snpAddr), .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .busy(busy)
  );

  // Behavioural reference model
  bit          mR[FR];
  bit          mC[FR];
  int          mSel;
  bit          mBusy;
  int          mSw;
  logic [31:0] mRd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic modelEdge(input logic sv, sw, input logic [31:0] sa,
                           input logic iv, iw, input logic [1:0] ia, input logic [31:0] wd);
    int  pg;
    bit  startOk;
    pg = int'(sa >> 12);
    if (iv && !iw) begin
      case (ia)
        2'd0: mRd = 32'(mSel);
        2'd1: mRd = {30'd0, mC[mSel], mR[mSel]};
        2'd2: mRd = {31'd0, mBusy};
        default: mRd = '0;
      endcase
    end
    startOk = iv && iw && ia == 2'd2 && wd[0] && !mBusy;
    if (mBusy) begin mR[mSw] = 0; mC[mSw] = 0; end
    if (iv && iw && ia == 2'd1) begin
      if (wd[0]) mR[mSel] = 0;
      if (wd[1]) mC[mSel] = 0;
    end
    if (sv && pg < FR && pg != WIN_PAGE) begin
      mR[pg] = 1;
      if (sw) mC[pg] = 1;
    end
    if (iv && iw && ia == 2'd0) mSel = int'(wd[7:0]);
    if (startOk) begin mBusy = 1; mSw = 0; end
    else if (mBusy) begin
      if (mSw == FR - 1) mBusy = 0;
      mSw++;
    end
  endtask

  // Drive between edges, model the edge, compare every clock (R6, R9).
  task automatic step(input logic sv, sw, input logic [31:0] sa,
                      input logic iv, iw, input logic [1:0] ia, input logic [31:0] wd);
    snpValid = sv; snpWrite = sw; snpAddr = sa;
    ioValid = iv; ioWrite = iw; ioAddr = ia; ioWdata = wd;
    @(posedge clk);
    modelEdge(sv, sw, sa, iv, iw, ia, wd);
    #1;
    check(ioRdata === mRd, "R6 per-clock read data vs model", ioRdata, mRd);
    check(busy === mBusy, "R9 per-clock busy vs model", 32'(busy), 32'(mBusy));
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, 2'd0, '0);
  endtask

  task automatic snp(input logic w, input logic [31:0] a);
    step(1, w, a, 0, 0, 2'd0, '0);
  endtask

  task automatic ioWr(input logic [1:0] a, input logic [31:0] d);
    step(0, 0, '0, 1, 1, a, d);
  endtask

  task automatic ioRd(input logic [1:0] a);
    step(0, 0, '0, 1, 0, a, '0);
  endtask

  task automatic expectBits(input int f, input logic [31:0] exp, input string tag);
    ioWr(2'd0, 32'(f));
    ioRd(2'd1);
    check(ioRdata === exp, tag, ioRdata, exp);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < FR; i++) begin mR[i] = 0; mC[i] = 0; end
    mSel = 0; mBusy = 0; mSw = 0; mRd = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    check(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);
    check(ioRdata === 32'd0, "R1 rdata after reset", ioRdata, 0);
    @(negedge clk);
    expectBits(7, 32'd0, "R1 frame 7 clear after reset");

    snp(0, 32'h0000_3010);
    expectBits(3, 32'd1, "R2 read marks referenced only");

    snp(1, 32'h0000_5ffc);
    expectBits(5, 32'd3, "R3 write marks referenced and changed");

    snp(1, 32'h0010_0000);
    snp(0, 32'h8000_0000);
    expectBits(0, 32'd0, "R4 out-of-range page aliasing frame 0 ignored");

    snp(1, 32'h000F_F004);
    expectBits(255, 32'd0, "R5 register window access ignored");
    snp(1, 32'h000F_E000);
    expectBits(254, 32'd3, "R5 neighbour of window still tracked");

    ioWr(2'd0, 32'd5);
    ioRd(2'd0);
    check(ioRdata === 32'd5, "R6 selector readback", ioRdata, 32'd5);
    ioRd(2'd3);
    check(ioRdata === 32'd0, "R6 reserved register reads zero", ioRdata, 0);
    idle(); idle();
    check(ioRdata === 32'd0, "R6 read data held between reads", ioRdata, 0);

    ioWr(2'd0, 32'd5);
    ioWr(2'd1, 32'd1);
    ioRd(2'd1);
    check(ioRdata === 32'd2, "R7 mask bit0 clears referenced only", ioRdata, 32'd2);
    ioWr(2'd1, 32'd2);
    ioRd(2'd1);
    check(ioRdata === 32'd0, "R7 mask bit1 clears changed", ioRdata, 0);

    // Collision: clear and snoop on selected frame 3 in the same cycle
    ioWr(2'd0, 32'd3);
    step(1, 0, 32'h0000_3000, 1, 1, 2'd1, 32'd3);
    ioRd(2'd1);
    check(ioRdata === 32'd1, "R8 snoop read beats clear", ioRdata, 32'd1);
    step(1, 1, 32'h0000_3abc, 1, 1, 2'd1, 32'd3);
    ioRd(2'd1);
    check(ioRdata === 32'd3, "R8 snoop write beats clear", ioRdata, 32'd3);

    // Sweep
    snp(1, 32'h000C_8000);
    expectBits(200, 32'd3, "R9 frame 200 set before sweep");
    ioWr(2'd2, 32'd1);
    begin
      int busyCycles = 0;
      for (int k = 0; k < FR + 4; k++) begin
        if (busy) busyCycles++;
        if (k == 10)      step(1, 1, 32'h0000_A000, 0, 0, 2'd0, '0);
        else if (k == 50) step(1, 0, 32'h0000_2000, 0, 0, 2'd0, '0);
        else if (k == 60) step(0, 0, '0, 1, 1, 2'd2, 32'd1);
        else if (k == 70) begin
          ioRd(2'd2);
          check(ioRdata === 32'd1, "R11 status shows busy", ioRdata, 32'd1);
        end
        else idle();
      end
      check(busyCycles == FR, "R9 busy length / R11 restart ignored",
            32'(busyCycles), 32'(FR));
    end
    expectBits(10, 32'd3, "R10 set on frame under sweep wins");
    expectBits(2, 32'd1, "R10 set after frame swept persists");
    expectBits(200, 32'd0, "R9 sweep cleared frame 200");
    expectBits(3, 32'd0, "R9 sweep cleared frame 3");
    ioRd(2'd2);
    check(ioRdata === 32'd0, "R11 status idle after sweep", ioRdata, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule